// File: doc/BRIEF.md
# Edge/Level Interrupt Bank

This block is one bank of an interrupt controller: it serves a group of interrupt lines behind a 32-bit word-addressed register interface. Each line carries its own configuration word, which holds a small priority value, a sensitivity selector (edge or level) and a routing bit that sends the line to the fast-interrupt channel instead of the normal one. Inputs pass through a synchronizer. In edge mode a line's pending bit is latched on a rising transition. In level mode it follows the input and any software-raised request.

The bank exports, per channel, the vector of pending and unmasked lines and a flat vector of per-line priorities to an external priority selector. It takes back the two winner codes. A read of a winner-code register returns that code and, as a side effect, acknowledges the winning line if that line is edge-sensitive. Each channel has an agreement output. It rises once when candidates appear and stays high until software re-arms it through the control register. A chip places several banks at a 0x100 byte stride and decodes the bank select outside this block.

Top module: `intc_bank`

## Requirements
- R1: After reset, the pending, software-raised, sensitivity, routing and priority state are all zero, the mask register (offset 0x04) reads all ones, and both agreement outputs are low.
- R2: The configuration word of line n is at offset 0x1C + 4n. Bits [6:2] hold the priority, bit 1 selects level mode when 1 and edge mode when 0, and bit 0 routes the line to the fast channel when 1. Other bits read 0. The priority of line n appears on `prio_flat[5n+4:5n]`.
- R3: An edge-mode line's pending bit (offset 0x00) becomes readable after the third rising clock edge that follows a 0-to-1 change of its input. It stays set after the input falls.
- R4: A level-mode line is pending while its synchronized input is high or its software-raised bit is set. It clears three edges after the input falls if no software request holds it.
- R5: A write to offset 0x00 clears each pending bit written as 0 together with its software-raised bit. A level-mode line whose input is still high stays pending.
- R6: Writing 1s to offset 0x0C sets the matching software-raised bits and pending bits at the write edge. Writing 0s has no effect.
- R7: A read of offset 0x10 returns `irq_code` and a read of offset 0x14 returns `fiq_code` in the same cycle. At that read's clock edge, the named line's pending and software-raised bits clear if the line is in edge mode. A level-mode line is untouched.
- R8: The mask register is read/write, and a mask bit of 1 blocks the line. `irq_cand` lists the pending, unmasked lines routed to the normal channel, and `fiq_cand` lists those routed to the fast channel.
- R9: While its channel is armed, an agreement output rises at the edge after its candidate vector becomes non-zero. It then disarms and stays high.
- R10: Writing offset 0x18 with bit 0 set re-arms the normal channel, and with bit 1 set re-arms the fast channel. The matching output is low after that edge, and it is re-evaluated from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N | Raw interrupt inputs, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the acknowledge side effect) |
| addr | input | 8 | Byte offset within the bank |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_code | input | 5 | Winner line of the normal channel, from the selector |
| fiq_code | input | 5 | Winner line of the fast channel, from the selector |
| irq_cand | output | N | Pending, unmasked lines on the normal channel |
| fiq_cand | output | N | Pending, unmasked lines on the fast channel |
| prio_flat | output | 5*N | Per-line priorities, line n at bits [5n+4:5n] |
| irq_o | output | 1 | Normal-channel agreement output |
| fiq_o | output | 1 | Fast-channel agreement output |

## Verification
Read data is combinational, so it is due in the cycle of the request. Every register side effect (configuration, mask, pending clear, acknowledge, re-arm) lands on the next rising edge. An input change reaches the pending bit and the candidate vectors three edges later, and the agreement outputs one edge after that. The bench drives every stimulus just after a falling edge and updates its reference model on each rising edge. One time unit after each falling edge it compares every output and the read data with the model, so each result is checked in the cycle it is due. Directed checks with fixed expected values read the pending register only once the three-edge capture delay has elapsed.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int PRIO_W = 5;

  localparam logic [ADDR_W-1:0] OFF_PEND     = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK     = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_SWI      = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_IRQ_CODE = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FIQ_CODE = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CTRL     = 8'h18;
  localparam int                OFF_CFG      = 'h1C;

  // configuration word layout: priority above level select above routing
  function automatic logic [DATA_W-1:0] cfg_pack(logic [PRIO_W-1:0] prio,
                                                 logic lvl, logic fast);
    return {{(DATA_W-PRIO_W-2){1'b0}}, prio, lvl, fast};
  endfunction

  function automatic logic [PRIO_W-1:0] cfg_prio(logic [DATA_W-1:0] w);
    return w[PRIO_W+1:2];
  endfunction
endpackage

// File: rtl/intc_capture.sv
module intc_capture
  import intc_pkg::*;
#(
  parameter int N    = 32,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] lvl,
  input  logic         pend_we,
  input  logic [N-1:0] pend_wval,
  input  logic [N-1:0] swi_set,
  input  logic [N-1:0] ack_vec,
  output logic [N-1:0] pend,
  output logic [N-1:0] swi
);
  logic [SYNC-1:0][N-1:0] sync_q;
  logic [N-1:0] prev_q, pend_q, swi_q;
  logic [N-1:0] samp, rise, wr_zero, swi_clr, swi_d, edge_d, pend_d;

  assign samp = sync_q[SYNC-1];

  always_comb begin
    rise    = samp & ~prev_q;
    wr_zero = pend_we ? ~pend_wval : '0;
    swi_clr = wr_zero | (ack_vec & ~lvl);
    swi_d   = (swi_q & ~swi_clr) | swi_set;
    edge_d  = (pend_q & ~(wr_zero | ack_vec)) | rise | swi_set;
    pend_d  = (lvl & (samp | swi_d)) | (~lvl & edge_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
      pend_q <= '0;
      swi_q  <= '0;
    end else begin
      sync_q[0] <= line_in;
      for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= samp;
      pend_q <= pend_d;
      swi_q  <= swi_d;
    end
  end

  assign pend = pend_q;
  assign swi  = swi_q;
endmodule

// File: rtl/intc_cfg.sv
module intc_cfg
  import intc_pkg::*;
#(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IW-1:0]       cfg_idx,
  input  logic                mask_we,
  input  logic [DATA_W-1:0]   wdata,
  output logic [N-1:0]        mask,
  output logic [N-1:0]        lvl,
  output logic [N-1:0]        fast,
  output logic [N*PRIO_W-1:0] prio_flat,
  output logic [DATA_W-1:0]   cfg_word
);
  logic [PRIO_W-1:0] prio_arr [N];
  logic [N-1:0]      mask_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [PRIO_W-1:0] prio_r;
    logic              lvl_r, fast_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_r <= '0;
        lvl_r  <= 1'b0;
        fast_r <= 1'b0;
      end else if (cfg_we && cfg_idx == IW'(g)) begin
        prio_r <= cfg_prio(wdata);
        lvl_r  <= wdata[1];
        fast_r <= wdata[0];
      end
    end
    assign prio_arr[g] = prio_r;
    assign lvl[g]      = lvl_r;
    assign fast[g]     = fast_r;
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= wdata[N-1:0];
  end

  assign mask     = mask_q;
  assign cfg_word = cfg_pack(prio_arr[cfg_idx], lvl[cfg_idx], fast[cfg_idx]);
endmodule

// File: rtl/intc_agree.sv
module intc_agree (
  input  logic clk,
  input  logic rst_n,
  input  logic cand_any,
  input  logic rearm,
  output logic out
);
  logic armed_q, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
    end else if (rearm) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
    end else if (armed_q && cand_any) begin
      armed_q <= 1'b0;
      out_q   <= 1'b1;
    end
  end

  assign out = out_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int N    = 32,
  parameter int SYNC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        line_in,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [$clog2(N)-1:0] irq_code,
  input  logic [$clog2(N)-1:0] fiq_code,
  output logic [N-1:0]        irq_cand,
  output logic [N-1:0]        fiq_cand,
  output logic [N*PRIO_W-1:0] prio_flat,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int IW = $clog2(N);

  function automatic logic [N-1:0] line_sel(logic [IW-1:0] code);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (code == IW'(i));
    return v;
  endfunction

  logic          cfg_hit, irq_ack, fiq_ack, rearm_irq, rearm_fiq;
  logic [IW-1:0] cfg_idx;
  logic [N-1:0]  ack_vec, swi_set, pend_q, swi_q, mask_q, lvl_q, fast_q;
  logic [DATA_W-1:0] cfg_word;

  assign cfg_hit = int'(addr) >= OFF_CFG && int'(addr) < OFF_CFG + 4*N &&
                   addr[1:0] == 2'b00;
  assign cfg_idx = IW'((int'(addr) - OFF_CFG) >> 2);
  assign irq_ack = rd_en && addr == OFF_IRQ_CODE;
  assign fiq_ack = rd_en && addr == OFF_FIQ_CODE;
  assign ack_vec = (irq_ack ? line_sel(irq_code) : '0) |
                   (fiq_ack ? line_sel(fiq_code) : '0);
  assign swi_set = (wr_en && addr == OFF_SWI) ? wdata[N-1:0] : '0;
  assign rearm_irq = wr_en && addr == OFF_CTRL && wdata[0];
  assign rearm_fiq = wr_en && addr == OFF_CTRL && wdata[1];

  intc_capture #(.N(N), .SYNC(SYNC)) u_cap (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .lvl(lvl_q),
    .pend_we(wr_en && addr == OFF_PEND), .pend_wval(wdata[N-1:0]),
    .swi_set(swi_set), .ack_vec(ack_vec), .pend(pend_q), .swi(swi_q)
  );

  intc_cfg #(.N(N)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(wr_en && cfg_hit), .cfg_idx(cfg_idx),
    .mask_we(wr_en && addr == OFF_MASK), .wdata(wdata), .mask(mask_q),
    .lvl(lvl_q), .fast(fast_q), .prio_flat(prio_flat), .cfg_word(cfg_word)
  );

  assign irq_cand = pend_q & ~mask_q & ~fast_q;
  assign fiq_cand = pend_q & ~mask_q & fast_q;

  intc_agree u_agr_irq (
    .clk(clk), .rst_n(rst_n), .cand_any(|irq_cand), .rearm(rearm_irq), .out(irq_o)
  );
  intc_agree u_agr_fiq (
    .clk(clk), .rst_n(rst_n), .cand_any(|fiq_cand), .rearm(rearm_fiq), .out(fiq_o)
  );

  always_comb begin
    rdata = '0;
    if (cfg_hit) rdata = cfg_word;
    else begin
      case (addr)
        OFF_PEND:     rdata = DATA_W'(pend_q);
        OFF_MASK:     rdata = DATA_W'(mask_q);
        OFF_SWI:      rdata = DATA_W'(swi_q);
        OFF_IRQ_CODE: rdata = DATA_W'(irq_code);
        OFF_FIQ_CODE: rdata = DATA_W'(fiq_code);
        default:      rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_bank_chk.sv
module intc_bank_chk
  import intc_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [N-1:0]      irq_cand,
  input logic [N-1:0]      pend,
  input logic              irq_o,
  input logic              fiq_o
);
  logic ctrl_irq, ctrl_fiq, swi_wr;
  assign ctrl_irq = wr_en && addr == OFF_CTRL && wdata[0];
  assign ctrl_fiq = wr_en && addr == OFF_CTRL && wdata[1];
  assign swi_wr   = wr_en && addr == OFF_SWI;

  a_r10_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_irq |=> !irq_o);
  a_r10_fiq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_fiq |=> !fiq_o);
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ctrl_irq) |=> irq_o);
  a_r9_rise_needs_cand: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|irq_cand));
  a_r6_swi_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    swi_wr |=> ((pend & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));
endmodule

bind intc_bank intc_bank_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_cand(irq_cand), .pend(pend_q), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/tb_intc_bank.sv
module tb_intc_bank;
  localparam int PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] line_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0] irq_code = '0, fiq_code = '0;
  logic [N-1:0] irq_cand, fiq_cand;
  logic [N*5-1:0] prio_flat;
  logic irq_o, fiq_o;

  int checks = 0, errors = 0;

  intc_bank dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_code(irq_code),
    .fiq_code(fiq_code), .irq_cand(irq_cand), .fiq_cand(fiq_cand),
    .prio_flat(prio_flat), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit [31:0] m_s1, m_s2, m_prev, m_pend, m_swi, m_mask, m_lvl, m_fast;
  int m_prio [N];
  bit m_armed [2];
  bit m_out [2];

  always @(posedge clk) begin
    bit [31:0] np, ns;
    bit act, rose, wclr, ack, sset, sw, p, any;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_swi = 0;
      m_mask = '1; m_lvl = 0; m_fast = 0;
      for (int i = 0; i < N; i++) m_prio[i] = 0;
      for (int c = 0; c < 2; c++) begin m_armed[c] = 1; m_out[c] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        act  = m_s2[i];
        rose = act && !m_prev[i];
        wclr = wr_en && addr == 8'h00 && !wdata[i];
        ack  = rd_en && ((addr == 8'h10 && irq_code == i) ||
                         (addr == 8'h14 && fiq_code == i));
        sset = wr_en && addr == 8'h0C && wdata[i];
        sw = m_swi[i];
        if (wclr || (ack && !m_lvl[i])) sw = 0;
        if (sset) sw = 1;
        if (m_lvl[i]) p = act || sw;
        else begin
          p = m_pend[i];
          if (wclr || ack) p = 0;
          if (rose || sset) p = 1;
        end
        np[i] = p; ns[i] = sw;
      end
      for (int c = 0; c < 2; c++) begin
        any = |(m_pend & ~m_mask & (c == 1 ? m_fast : ~m_fast));
        if (wr_en && addr == 8'h18 && wdata[c]) begin m_out[c] = 0; m_armed[c] = 1; end
        else if (m_armed[c] && any) begin m_out[c] = 1; m_armed[c] = 0; end
      end
      if (wr_en && addr == 8'h04) m_mask = wdata;
      if (wr_en && addr >= 8'h1C && addr < 8'h9C && addr[1:0] == 0) begin
        m_prio[(addr - 8'h1C) / 4] = int'(wdata[6:2]);
        m_lvl[(addr - 8'h1C) / 4]  = wdata[1];
        m_fast[(addr - 8'h1C) / 4] = wdata[0];
      end
      m_pend = np; m_swi = ns;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = line_in;
    end
  end

  function automatic logic [31:0] mread(logic [7:0] a);
    int k;
    if (a >= 8'h1C && a < 8'h9C && a[1:0] == 0) begin
      k = (a - 8'h1C) / 4;
      return (m_prio[k] << 2) | (32'(m_lvl[k]) << 1) | 32'(m_fast[k]);
    end
    case (a)
      8'h00: return m_pend;
      8'h04: return m_mask;
      8'h0C: return m_swi;
      8'h10: return 32'(irq_code);
      8'h14: return 32'(fiq_code);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    logic [N*5-1:0] ep;
    #1;
    if (rst_n) begin
      for (int i = 0; i < N; i++) ep[i*5 +: 5] = 5'(m_prio[i]);
      chk("R8 irq_cand", irq_cand, m_pend & ~m_mask & ~m_fast);
      chk("R8 fiq_cand", fiq_cand, m_pend & ~m_mask & m_fast);
      chk("R9 irq_o", 32'(irq_o), 32'(m_out[0]));
      chk("R10 fiq_o", 32'(fiq_o), 32'(m_out[1]));
      checks++;
      if (prio_flat !== ep) begin
        errors++;
        $display("FAIL R2 prio_flat actual=%h expected=%h", prio_flat, ep);
      end
      chk("R7 rdata", rdata, mread(addr));
    end
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) tick(); endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; tick(); wr_en = 0; addr = 8'hFC;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a; #2 d = rdata; tick(); rd_en = 0; addr = 8'hFC;
  endtask

  bit done = 0;
  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    bus_rd(8'h00, d); chk("R1 pend", d, 0);
    bus_rd(8'h04, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    bus_rd(8'h20, d); chk("R1 cfg", d, 0);
    chk("R1 irq_o", 32'(irq_o), 0);
    // R2 configuration word
    bus_wr(8'h24, 32'hFFFF_FF80 | 32'h25);
    bus_rd(8'h24, d); chk("R2 cfg readback", d, 32'h25);
    chk("R2 prio_flat", 32'(prio_flat[10 +: 5]), 9);
    // R3 edge capture and persistence
    bus_wr(8'h04, 0);
    line_in[3] = 1; ticks(3);
    bus_rd(8'h00, d); chk("R3 edge set", d, 32'h8);
    line_in[3] = 0; ticks(3);
    bus_rd(8'h00, d); chk("R3 persists", d, 32'h8);
    // R5 write-zero clear of an edge line
    bus_wr(8'h00, ~32'h8);
    bus_rd(8'h00, d); chk("R5 edge cleared", d, 0);
    // R4 level capture
    bus_wr(8'h30, 32'h2);
    line_in[5] = 1; ticks(3);
    bus_rd(8'h00, d); chk("R4 level set", d, 32'h20);
    bus_wr(8'h00, 0);
    bus_rd(8'h00, d); chk("R5 level kept", d, 32'h20);
    line_in[5] = 0; ticks(3);
    bus_rd(8'h00, d); chk("R4 level clear", d, 0);
    // R6 software raise holds a level line
    bus_wr(8'h0C, 32'h20);
    bus_rd(8'h00, d); chk("R6 swi set", d, 32'h20);
    ticks(3);
    bus_rd(8'h00, d); chk("R4 swi holds", d, 32'h20);
    bus_wr(8'h00, 0);
    bus_rd(8'h0C, d); chk("R5 swi cleared", d, 0);
    // R7 acknowledge of an edge line
    line_in[3] = 1; ticks(3);
    irq_code = 3;
    bus_rd(8'h10, d); chk("R7 irq code", d, 3);
    bus_rd(8'h00, d); chk("R7 edge acked", d, 0);
    // R7 level line not acknowledged
    line_in[5] = 1; ticks(3);
    irq_code = 5;
    bus_rd(8'h10, d); chk("R7 irq code lvl", d, 5);
    bus_rd(8'h00, d); chk("R7 level kept", d, 32'h20);
    line_in[5] = 0; ticks(3);
    // R8 fast routing and fast acknowledge
    line_in[2] = 1; ticks(3);
    chk("R8 fiq_cand", fiq_cand, 32'h4);
    tick();
    chk("R9 fiq_o", 32'(fiq_o), 1);
    fiq_code = 2;
    bus_rd(8'h14, d); chk("R7 fiq code", d, 2);
    bus_rd(8'h00, d); chk("R7 fast acked", d, 0);
    // R8 mask blocks
    bus_wr(8'h04, 32'h8);
    line_in[3] = 0; ticks(2); line_in[3] = 1; ticks(3);
    bus_rd(8'h00, d); chk("R8 masked pend", d, 32'h8);
    chk("R8 masked cand", irq_cand, 0);
    bus_rd(8'h04, d); chk("R8 mask read", d, 32'h8);
    // R9 hold and R10 re-arm
    chk("R9 irq held", 32'(irq_o), 1);
    bus_wr(8'h18, 32'h1);
    chk("R10 irq dropped", 32'(irq_o), 0);
    ticks(2);
    chk("R10 stays low", 32'(irq_o), 0);
    bus_wr(8'h04, 0);
    tick();
    chk("R9 irq rises", 32'(irq_o), 1);
    bus_wr(8'h18, 32'h3);
    chk("R10 both dropped", 32'(irq_o | fiq_o), 0);
    ticks(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule